// File: doc/BRIEF.md
# Serial Converter Read Controller

This block is the host side of a three-wire link to a 16-bit serial analog-to-digital converter. On a start request it pulls the active-low select line down. It then derives a serial clock from the system clock through a divider that is set at run time. The converter shifts out one bit per serial clock period, and the block collects the bits into a parallel word. At the end of a full read it presents the word with a one-cycle valid strobe.

A command bit taken with each start request chooses the kind of frame. A read frame runs all sixteen serial clock periods. A power-down frame releases select early, after a fixed number of falling edges. That count lies well after the point below which an early release is ignored, and well before the point past which the converter stays powered. A power-down frame yields no data. After any frame, select is held high for a quiet interval set at run time, and the block reports busy until that interval has run out.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After reset, `cs_n_o` and `sclk_o` are high, and `busy_o`, `valid_o` and `result_o` are zero.
- R2: A start request is accepted when `start_i` is high while `busy_o` is low. On the next clock edge `cs_n_o` goes low and `busy_o` goes high.
- R3: `sclk_o` is high whenever select is released. While select is low, every serial clock half-period lasts `div_i`+1 system clocks, as latched at acceptance. The first falling edge comes one half-period after select falls.
- R4: `sdata_i` is sampled on the system clock edge at which `sclk_o` returns high after each falling edge. Bits are shifted in first-bit-most-significant.
- R5: In a read frame (`pd_cmd_i`=0) select rises on the same clock that `sclk_o` rises after the 16th falling edge. At that point `result_o` takes the 16 sampled bits, with the first sampled bit in bit 15.
- R6: `valid_o` is high for exactly one clock, together with the new `result_o`, and only at the end of a full read frame. `result_o` does not change at any other time.
- R7: In a power-down frame (`pd_cmd_i`=1) select rises with the `sclk_o` rise that follows falling edge number PD_FALLS (default 4, legal range 3 to 9). The frame raises no `valid_o` and leaves `result_o` unchanged.
- R8: After select rises, `busy_o` stays high for `quiet_i`+1 further clocks, using the value latched at acceptance. Select therefore stays high for at least `quiet_i`+2 clocks before the next frame.
- R9: A start request made while `busy_o` is high is ignored and is not queued.
- R10: Changes to `div_i`, `quiet_i` and `pd_cmd_i` after a frame has been accepted do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame request |
| pd_cmd_i | input | 1 | 1 selects a power-down frame, 0 a read frame |
| div_i | input | DIV_W | Serial clock half-period minus one, in system clocks |
| quiet_i | input | QUIET_W | Quiet interval length after a frame |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock, idles high |
| result_o | output | FRAME_BITS | Last complete conversion word |
| valid_o | output | 1 | One-cycle strobe for a new result |
| busy_o | output | 1 | Frame or quiet interval in progress |

## Verification
The assertions check on every cycle the following. Select and the serial clock are never both low while released. A select falling edge happens only out of the idle state. Each select release lands on the expected falling-edge count for the frame type. The valid strobe is a single cycle tied to a sample, the result register holds between strobes, and the divider count stays within its latched bound. The bench's scenarios alone can show the data bit order and the exact half-period length for several divider settings. They also show that requests during busy and input changes mid-frame have no effect, and that the quiet gap lasts its full length with the start request held high.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_QUIET  = 2'd2
  } frame_state_e;

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             tick;

  always_comb begin
    tick  = run_i && (cnt_q == half_i);
    cnt_d = cnt_q;
    if (!run_i || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = tick;

  // R3: the half-period counter never runs past its latched limit
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= half_i));

endmodule

// File: rtl/adc_shift_capture.sv
module adc_shift_capture #(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_i,
  input  logic                  commit_i,
  input  logic                  sdata_i,
  output logic [FRAME_BITS-1:0] result_o,
  output logic                  valid_o
);

  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [FRAME_BITS-1:0] res_q, res_d;
  logic                  vld_q, vld_d;

  always_comb begin
    sh_d  = sh_q;
    res_d = res_q;
    vld_d = 1'b0;
    if (sample_i) begin
      sh_d = {sh_q[FRAME_BITS-2:0], sdata_i};
      if (commit_i) begin
        res_d = sh_d;
        vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (sample_i) begin
        sh_q <= sh_d;
      end
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign result_o = res_q;
  assign valid_o  = vld_q;

  // R6: strobe lasts one clock
  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R6: a strobe always follows a sample
  assert_valid_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(sample_i));

  // R6: the result only moves with the strobe
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(result_o));

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_ctrl_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int QUIET_W    = 8,
  parameter int FRAME_BITS = 16,
  parameter int PD_FALLS   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               pd_cmd_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [QUIET_W-1:0] quiet_i,
  input  logic               tick_i,
  output logic               run_o,
  output logic [DIV_W-1:0]   half_o,
  output logic               sample_o,
  output logic               commit_o,
  output logic               cs_n_o,
  output logic               sclk_o,
  output logic               busy_o
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] PD_CNT   = CNT_W'(PD_FALLS);

  frame_state_e       state_q, state_d;
  logic               cs_n_q, cs_n_d;
  logic               sclk_q, sclk_d;
  logic [CNT_W-1:0]   falls_q, falls_d;
  logic               pd_q, pd_d;
  logic [DIV_W-1:0]   half_q, half_d;
  logic [QUIET_W-1:0] qcnt_q, qcnt_d;

  logic               rise, fall, last;
  logic [CNT_W-1:0]   end_cnt;

  always_comb begin
    rise    = tick_i && !sclk_q;
    fall    = tick_i && sclk_q;
    end_cnt = pd_q ? PD_CNT : FULL_CNT;
    last    = rise && (falls_q == end_cnt);

    state_d = state_q;
    cs_n_d  = cs_n_q;
    sclk_d  = sclk_q;
    falls_d = falls_q;
    pd_d    = pd_q;
    half_d  = half_q;
    qcnt_d  = qcnt_q;

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_ACTIVE;
          cs_n_d  = 1'b0;
          sclk_d  = 1'b1;
          falls_d = '0;
          pd_d    = pd_cmd_i;
          half_d  = div_i;
          qcnt_d  = quiet_i;
        end
      end
      ST_ACTIVE: begin
        if (fall) begin
          sclk_d  = 1'b0;
          falls_d = falls_q + 1'b1;
        end
        if (rise) begin
          sclk_d = 1'b1;
          if (last) begin
            cs_n_d  = 1'b1;
            state_d = ST_QUIET;
          end
        end
      end
      ST_QUIET: begin
        if (qcnt_q == '0) begin
          state_d = ST_IDLE;
        end else begin
          qcnt_d = qcnt_q - 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cs_n_d  = 1'b1;
        sclk_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b1;
      falls_q <= '0;
      pd_q    <= 1'b0;
      half_q  <= '0;
      qcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
      falls_q <= falls_d;
      pd_q    <= pd_d;
      half_q  <= half_d;
      qcnt_q  <= qcnt_d;
    end
  end

  assign run_o    = (state_q == ST_ACTIVE);
  assign half_o   = half_q;
  assign sample_o = run_o && rise;
  assign commit_o = run_o && last && !pd_q;
  assign cs_n_o   = cs_n_q;
  assign sclk_o   = sclk_q;
  assign busy_o   = (state_q != ST_IDLE);

  // R3: the serial clock is only low inside a frame
  assert_sclk_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_o |-> !cs_n_o);

  // R9: select only falls out of the idle state
  assert_start_only_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> !$past(busy_o));

  // R5: a read frame ends on its sixteenth falling edge
  assert_read_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n_o) && !pd_q) |-> (falls_q == FULL_CNT));

  // R7: a power-down frame ends on its configured edge
  assert_pd_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n_o) && pd_q) |-> (falls_q == PD_CNT));

  // R5: select is released with the serial clock high
  assert_release_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> sclk_o);

  // R8: when not busy, select is released
  assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> cs_n_o);

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
  parameter int DIV_W      = 8,
  parameter int QUIET_W    = 8,
  parameter int FRAME_BITS = 16,
  parameter int PD_FALLS   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  pd_cmd_i,
  input  logic [DIV_W-1:0]      div_i,
  input  logic [QUIET_W-1:0]    quiet_i,
  input  logic                  sdata_i,
  output logic                  cs_n_o,
  output logic                  sclk_o,
  output logic [FRAME_BITS-1:0] result_o,
  output logic                  valid_o,
  output logic                  busy_o
);

  generate
    if (PD_FALLS < 3 || PD_FALLS > 9) begin : g_bad_pd_falls
      $error("PD_FALLS must lie between 3 and 9");
    end
  endgenerate

  logic             run;
  logic [DIV_W-1:0] half;
  logic             tick;
  logic             sample;
  logic             commit;

  adc_frame_seq #(
    .DIV_W      (DIV_W),
    .QUIET_W    (QUIET_W),
    .FRAME_BITS (FRAME_BITS),
    .PD_FALLS   (PD_FALLS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .pd_cmd_i (pd_cmd_i),
    .div_i    (div_i),
    .quiet_i  (quiet_i),
    .tick_i   (tick),
    .run_o    (run),
    .half_o   (half),
    .sample_o (sample),
    .commit_o (commit),
    .cs_n_o   (cs_n_o),
    .sclk_o   (sclk_o),
    .busy_o   (busy_o)
  );

  adc_sclk_div #(
    .DIV_W (DIV_W)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .half_i (half),
    .tick_o (tick)
  );

  adc_shift_capture #(
    .FRAME_BITS (FRAME_BITS)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (sample),
    .commit_i (commit),
    .sdata_i  (sdata_i),
    .result_o (result_o),
    .valid_o  (valid_o)
  );

endmodule

// File: tb/adc_frame_ctrl_bench.sv
module adc_frame_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PD_FALLS   = 4;
  localparam int WATCHDOG   = 150000;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        pd_cmd_i;
  logic [7:0]  div_i;
  logic [7:0]  quiet_i;
  logic        sdata_i;
  logic        cs_n_o;
  logic        sclk_o;
  logic [15:0] result_o;
  logic        valid_o;
  logic        busy_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  adc_frame_ctrl #(.PD_FALLS(PD_FALLS)) u_adc_frame_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .pd_cmd_i (pd_cmd_i),
    .div_i    (div_i),
    .quiet_i  (quiet_i),
    .sdata_i  (sdata_i),
    .cs_n_o   (cs_n_o),
    .sclk_o   (sclk_o),
    .result_o (result_o),
    .valid_o  (valid_o),
    .busy_o   (busy_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // converter model: drives bits MSB first on each serial clock fall
  logic [15:0] conv_word;
  int          conv_idx;
  always @(negedge cs_n_o) conv_idx = 15;
  always @(negedge sclk_o) begin
    if (!cs_n_o) begin
      sdata_i = (conv_idx >= 0) ? conv_word[conv_idx] : 1'b0;
      conv_idx = conv_idx - 1;
    end
  end

  // behavioural reference model, advanced on every rising clock edge
  int          m_st;    // 0 idle, 1 in frame, 2 quiet
  int          m_cnt, m_half, m_falls, m_qc, m_qlat;
  logic        m_cs, m_sk, m_pd, m_vld;
  logic [15:0] m_sh, m_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cs = 1; m_sk = 1; m_vld = 0; m_res = 0; m_cnt = 0;
      m_falls = 0; m_pd = 0; m_half = 0; m_qc = 0; m_qlat = 0; m_sh = 0;
    end else begin
      m_vld = 0;
      case (m_st)
        0: if (start_i) begin
          m_st = 1; m_cs = 0; m_sk = 1; m_cnt = 0; m_falls = 0;
          m_half = int'(div_i); m_qc = int'(quiet_i); m_qlat = m_qc; m_pd = pd_cmd_i;
        end
        1: begin
          if (m_cnt == m_half) begin
            m_cnt = 0;
            if (m_sk) begin
              m_sk = 0; m_falls++;
            end else begin
              m_sk = 1;
              m_sh = {m_sh[14:0], sdata_i};
              if (m_falls == (m_pd ? PD_FALLS : 16)) begin
                m_cs = 1; m_st = 2;
                if (!m_pd) begin m_res = m_sh; m_vld = 1; end
              end
            end
          end else m_cnt++;
        end
        default: if (m_qc == 0) m_st = 0; else m_qc--;
      endcase
    end
  end

  // per-clock comparison and frame-shape monitor
  logic p_cs = 1, p_sk = 1;
  int   mon_falls = 0, gap = 0, gap_need = 0;
  bit   seen_frame = 0;
  logic frame_pd = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cycles++;
      chk("R2 cs_n", cs_n_o, m_cs);
      chk("R3 R10 sclk", sclk_o, m_sk);
      chk("R4 R5 result", result_o, m_res);
      chk("R6 valid", valid_o, m_vld);
      chk("R8 R9 busy", busy_o, (m_st != 0));
      if (!cs_n_o && p_sk && !sclk_o) mon_falls++;
      if (p_cs && !cs_n_o) begin
        if (seen_frame) chk("R8 gap", (gap >= gap_need), 1);
        mon_falls = 0; frame_pd = m_pd;
      end
      if (!p_cs && cs_n_o) begin
        chk(frame_pd ? "R7 pd edges" : "R5 read edges", mon_falls, frame_pd ? PD_FALLS : 16);
        seen_frame = 1; gap = 0; gap_need = m_qlat + 2;
      end
      if (cs_n_o) gap++;
      p_cs = cs_n_o; p_sk = sclk_o;
    end
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  task automatic frame(input logic pd, input int dv, input int qt,
                       input logic [15:0] w, input bit poke);
    conv_word = w;
    @(negedge clk);
    start_i = 1; pd_cmd_i = pd; div_i = 8'(dv); quiet_i = 8'(qt);
    @(negedge clk);
    start_i = 0;
    if (poke) begin
      div_i = 8'(dv + 3); quiet_i = 8'(qt + 5); pd_cmd_i = ~pd;
      repeat (3) @(negedge clk);
      start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; start_i = 0; pd_cmd_i = 0; div_i = 0; quiet_i = 0;
    sdata_i = 0; conv_word = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 cs_n", cs_n_o, 1);
    chk("R1 sclk", sclk_o, 1);
    chk("R1 busy", busy_o, 0);
    chk("R1 valid", valid_o, 0);
    chk("R1 result", result_o, 0);
    rst_n = 1;
    frame(0, 0, 3, 16'hA5C3, 0);
    frame(0, 2, 0, 16'h0001, 0);
    frame(1, 1, 2, 16'hFFFF, 0);          // R7: power-down keeps result
    frame(0, 0, 1, 16'h8000, 0);
    frame(0, 1, 4, 16'h3C5A, 1);          // R9 R10: pokes mid-frame
    frame(1, 0, 6, 16'h1234, 1);
    frame(0, 3, 0, 16'hFFFF, 0);
    // start held high: back-to-back frames spaced by the quiet gap
    conv_word = 16'h6B2D;
    @(negedge clk);
    start_i = 1; pd_cmd_i = 0; div_i = 0; quiet_i = 2;
    repeat (150) @(negedge clk);
    start_i = 0;
    while (busy_o) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R8 idle release", cs_n_o, 1);
    finish_run();
  end

endmodule